// File: doc/BRIEF.md
# Sub-Block Matrix-Multiply Inner Updater

This block applies one inner-block update of a blocked, right-looking LU factorization: C ← C − A·B. Here C is a B×B block that still needs its update, A is the matching tile from the already-updated column to its left, and B is the matching tile from the already-updated row above it. The block needs no pivoting support and no traffic with neighbouring units. All three operands come from stored buffers and arrive over three independent valid/ready load ports. The updated block leaves over one valid/ready store port.

A `start_i` pulse opens a job, which runs through three phases. In the load phase each port takes B²/S words. In the compute phase the block issues one full S×S sub-block multiply-accumulate per clock. The loop order is row sub-block i, then column sub-block j, then k innermost. The S×S partial sum stays in registers across k and is written back once per (i,j), so the phase takes (B/S)³ cycles. In the store phase the block emits B²/S words and then pulses `done_o`. Elements are signed Q8.8. Products are summed exactly in a wide accumulator, and each result is saturated back to 16 bits.

B = 2^`BLK_LOG` and S = 2^`SUB_LOG`.

Top module: `blk_mm_update`

## Requirements
- R1: The load ready outputs are high only in the load phase. Each port accepts exactly B²/S words. Word w holds matrix row w / (B/S) and column sub-block w mod (B/S). Its element e (column (w mod (B/S))·S + e) sits in bits [16e+15:16e].
- R2: `st_vld_o` rises exactly (B/S)³ + 1 clock edges after the edge that accepts the final load word. No store word is offered during the compute phase.
- R3: Each stored element equals C − floor(Σₖ A[r][k]·B[k][c] / 256), taking all values as signed 16-bit Q8.8 and the sum as exact.
- R4: A result above 32767 is stored as 32767 (0x7FFF), and a result below −32768 is stored as −32768 (0x8000). An intermediate sum that exceeds 32 bits does not wrap.
- R5: The store port emits B²/S words in the same word order as the loads. While `st_vld_o` is high and `st_rdy_i` is low, `st_vld_o` stays high and `st_data_o` stays unchanged.
- R6: `done_o` is high for exactly one cycle: the cycle after the edge that accepts the final store word. In that cycle `busy_o` is already low.
- R7: `start_i` has no effect while `busy_o` is high. Load counts, results and store order are unaffected.
- R8: After reset, `busy_o`, `done_o`, `st_vld_o` and all load ready outputs are low.
- R9: The three load ports complete in any order and with any gaps. Compute starts only when all three have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job when idle |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse when a job ends |
| a_vld_i | input | 1 | Left-tile word valid |
| a_data_i | input | 16·S | Left-tile word (S elements) |
| a_rdy_o | output | 1 | Left-tile port ready |
| b_vld_i | input | 1 | Top-tile word valid |
| b_data_i | input | 16·S | Top-tile word |
| b_rdy_o | output | 1 | Top-tile port ready |
| c_vld_i | input | 1 | Target-block word valid |
| c_data_i | input | 16·S | Target-block word |
| c_rdy_o | output | 1 | Target-block port ready |
| st_vld_o | output | 1 | Result word valid |
| st_data_o | output | 16·S | Result word |
| st_rdy_i | input | 1 | Result word accepted |

## Verification
The bench builds three copies of the block:
- **B=16, S=4.** Four sub-blocks per side and a 64-cycle compute phase. This copy reaches accumulation across several k steps and write-back into every (i,j) position.
- **B=8, S=2.** Narrow words and 64 issue cycles with a different address split. This copy checks that the row and sub-block fields of a word index are decoded correctly.
- **B=4, S=4.** A single sub-block, where the first k step is also the last. This copy covers the degenerate one-cycle compute phase and a one-pass write-back.

On each copy, saturated operands drive the sums past 32 bits. Port-ordered loads, random gaps and random store stalls exercise the handshakes.

// File: rtl/blk_mm_pkg.sv
package blk_mm_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned FRAC_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_CALC,
    PH_STORE
  } phase_e;

  function automatic logic [DATA_W-1:0] sat_data(input logic signed [63:0] v);
    if (v > 64'sd32767) return 16'h7fff;
    if (v < -64'sd32768) return 16'h8000;
    return v[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/blk_mm_ldport.sv
module blk_mm_ldport #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          vld_i,
  output logic          rdy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          full_o
);

  logic [AW:0] cnt_q;

  assign full_o = (cnt_q == (AW+1)'(WORDS));
  assign rdy_o  = en_i && !full_o;
  assign we_o   = vld_i && rdy_o;
  assign addr_o = cnt_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (we_o)  cnt_q <= cnt_q + 1'b1;
  end

  p_no_overrun_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (full_o || $past(clr_i)));

endmodule

// File: rtl/blk_mm_core.sv
module blk_mm_core #(
  parameter int unsigned S     = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 36
) (
  input  logic                                first_i,
  input  logic [S-1:0][S-1:0][DW-1:0]         a_i,
  input  logic [S-1:0][S-1:0][DW-1:0]         b_i,
  input  logic [S-1:0][S-1:0][ACC_W-1:0]      acc_i,
  output logic [S-1:0][S-1:0][ACC_W-1:0]      sum_o
);

  for (genvar r = 0; r < S; r++) begin : g_row
    for (genvar c = 0; c < S; c++) begin : g_col
      always_comb begin
        logic signed [2*DW-1:0]  prod;
        logic signed [ACC_W-1:0] s;
        s = first_i ? '0 : $signed(acc_i[r][c]);
        for (int t = 0; t < S; t++) begin
          prod = $signed(a_i[r][t]) * $signed(b_i[t][c]);
          s    = s + ACC_W'(prod);
        end
        sum_o[r][c] = s;
      end
    end
  end

endmodule

// File: rtl/blk_mm_seq.sv
module blk_mm_seq
  import blk_mm_pkg::*;
#(
  parameter int unsigned NSB   = 4,
  parameter int unsigned WORDS = 64,
  parameter int unsigned IW    = 2,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          all_full_i,
  input  logic          st_rdy_i,
  output phase_e        phase_o,
  output logic          clr_o,
  output logic          issue_o,
  output logic          k_first_o,
  output logic          k_last_o,
  output logic [IW-1:0] i_o,
  output logic [IW-1:0] j_o,
  output logic [IW-1:0] k_o,
  output logic          st_vld_o,
  output logic [AW-1:0] st_addr_o,
  output logic          done_o
);

  localparam logic [IW-1:0] LAST  = IW'(NSB - 1);
  localparam logic [AW-1:0] WLAST = AW'(WORDS - 1);
  localparam int unsigned   CALC_CYC = NSB * NSB * NSB;

  phase_e        phase_q, phase_d;
  logic [IW-1:0] i_q, j_q, k_q;
  logic [AW-1:0] st_cnt_q;
  logic          done_q;
  logic          j_last, i_last, st_fire;

  assign k_last_o  = (k_q == LAST);
  assign j_last    = (j_q == LAST);
  assign i_last    = (i_q == LAST);
  assign k_first_o = (k_q == '0);
  assign issue_o   = (phase_q == PH_CALC);
  assign st_vld_o  = (phase_q == PH_STORE);
  assign st_fire   = st_vld_o && st_rdy_i;
  assign st_addr_o = st_cnt_q;
  assign i_o       = i_q;
  assign j_o       = j_q;
  assign k_o       = k_q;
  assign phase_o   = phase_q;
  assign done_o    = done_q;

  always_comb begin
    phase_d = phase_q;
    clr_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE:  if (start_i) begin phase_d = PH_LOAD; clr_o = 1'b1; end
      PH_LOAD:  if (all_full_i) phase_d = PH_CALC;
      PH_CALC:  if (k_last_o && j_last && i_last) phase_d = PH_STORE;
      PH_STORE: if (st_fire && st_cnt_q == WLAST) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      i_q      <= '0;
      j_q      <= '0;
      k_q      <= '0;
      st_cnt_q <= '0;
      done_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_STORE) && (phase_d == PH_IDLE);
      if (clr_o) begin
        i_q      <= '0;
        j_q      <= '0;
        k_q      <= '0;
        st_cnt_q <= '0;
      end else if (issue_o) begin
        k_q <= k_last_o ? '0 : k_q + 1'b1;
        if (k_last_o) begin
          j_q <= j_last ? '0 : j_q + 1'b1;
          if (j_last) i_q <= i_last ? '0 : i_q + 1'b1;
        end
      end else if (st_fire) begin
        st_cnt_q <= st_cnt_q + 1'b1;
      end
    end
  end

  logic [31:0] calc_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                calc_cnt_q <= '0;
    else if (phase_q == PH_CALC) calc_cnt_q <= calc_cnt_q + 1;
    else                         calc_cnt_q <= '0;
  end

  p_calc_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CALC && phase_d == PH_STORE) |-> (calc_cnt_q == CALC_CYC - 1));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CALC && start_i) |=> (phase_q == PH_CALC || phase_q == PH_STORE));

endmodule

// File: rtl/blk_mm_update.sv
module blk_mm_update
  import blk_mm_pkg::*;
#(
  parameter int unsigned BLK_LOG = 4,
  parameter int unsigned SUB_LOG = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        busy_o,
  output logic                        done_o,
  input  logic                        a_vld_i,
  input  logic [DATA_W*(1<<SUB_LOG)-1:0] a_data_i,
  output logic                        a_rdy_o,
  input  logic                        b_vld_i,
  input  logic [DATA_W*(1<<SUB_LOG)-1:0] b_data_i,
  output logic                        b_rdy_o,
  input  logic                        c_vld_i,
  input  logic [DATA_W*(1<<SUB_LOG)-1:0] c_data_i,
  output logic                        c_rdy_o,
  output logic                        st_vld_o,
  output logic [DATA_W*(1<<SUB_LOG)-1:0] st_data_o,
  input  logic                        st_rdy_i
);

  localparam int unsigned BW    = 1 << BLK_LOG;
  localparam int unsigned S     = 1 << SUB_LOG;
  localparam int unsigned NSB   = BW / S;
  localparam int unsigned WORDS = BW * NSB;
  localparam int unsigned WW    = DATA_W * S;
  localparam int unsigned AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned IW    = (NSB > 1) ? $clog2(NSB) : 1;
  localparam int unsigned ACC_W = 2 * DATA_W + BLK_LOG;

  // Port index: 0 = left tile, 1 = top tile, 2 = target block
  logic          ld_vld  [3];
  logic [WW-1:0] ld_data [3];
  logic          ld_rdy  [3];
  logic          ld_we   [3];
  logic [AW-1:0] ld_addr [3];
  logic          ld_full [3];

  assign ld_vld[0]  = a_vld_i;
  assign ld_vld[1]  = b_vld_i;
  assign ld_vld[2]  = c_vld_i;
  assign ld_data[0] = a_data_i;
  assign ld_data[1] = b_data_i;
  assign ld_data[2] = c_data_i;
  assign a_rdy_o    = ld_rdy[0];
  assign b_rdy_o    = ld_rdy[1];
  assign c_rdy_o    = ld_rdy[2];

  phase_e        phase;
  logic          clr, issue, k_first, k_last, done;
  logic [IW-1:0] si, sj, sk;
  logic [AW-1:0] st_addr;

  for (genvar g = 0; g < 3; g++) begin : g_ld
    blk_mm_ldport #(.WORDS(WORDS), .AW(AW)) u_ld (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (phase == PH_LOAD),
      .vld_i  (ld_vld[g]),
      .rdy_o  (ld_rdy[g]),
      .we_o   (ld_we[g]),
      .addr_o (ld_addr[g]),
      .full_o (ld_full[g])
    );
  end

  blk_mm_seq #(.NSB(NSB), .WORDS(WORDS), .IW(IW), .AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .all_full_i (ld_full[0] && ld_full[1] && ld_full[2]),
    .st_rdy_i   (st_rdy_i),
    .phase_o    (phase),
    .clr_o      (clr),
    .issue_o    (issue),
    .k_first_o  (k_first),
    .k_last_o   (k_last),
    .i_o        (si),
    .j_o        (sj),
    .k_o        (sk),
    .st_vld_o   (st_vld_o),
    .st_addr_o  (st_addr),
    .done_o     (done)
  );

  assign busy_o = (phase != PH_IDLE);
  assign done_o = done;

  logic [WW-1:0] mem_q [3][WORDS];

  // Sub-block operand gather
  logic [S-1:0][S-1:0][DATA_W-1:0] a_sub, b_sub, c_old;
  logic [S-1:0][S-1:0][ACC_W-1:0]  acc_q, sum;
  logic [AW-1:0]                   a_row_addr [S];
  logic [AW-1:0]                   b_row_addr [S];
  logic [AW-1:0]                   c_row_addr [S];

  for (genvar r = 0; r < S; r++) begin : g_gather
    assign a_row_addr[r] = AW'((int'(si) * S + r) * NSB + int'(sk));
    assign b_row_addr[r] = AW'((int'(sk) * S + r) * NSB + int'(sj));
    assign c_row_addr[r] = AW'((int'(si) * S + r) * NSB + int'(sj));
    for (genvar c = 0; c < S; c++) begin : g_el
      assign a_sub[r][c] = mem_q[0][a_row_addr[r]][c*DATA_W +: DATA_W];
      assign b_sub[r][c] = mem_q[1][b_row_addr[r]][c*DATA_W +: DATA_W];
      assign c_old[r][c] = mem_q[2][c_row_addr[r]][c*DATA_W +: DATA_W];
    end
  end

  blk_mm_core #(.S(S), .DW(DATA_W), .ACC_W(ACC_W)) u_core (
    .first_i (k_first),
    .a_i     (a_sub),
    .b_i     (b_sub),
    .acc_i   (acc_q),
    .sum_o   (sum)
  );

  // Write-back value: C - (sum >> FRAC), saturated
  logic [S-1:0][WW-1:0] wb_row;
  for (genvar r = 0; r < S; r++) begin : g_wb
    for (genvar c = 0; c < S; c++) begin : g_wbe
      logic signed [63:0] c_ext, p_ext;
      assign c_ext = 64'($signed(c_old[r][c]));
      assign p_ext = 64'($signed(sum[r][c])) >>> FRAC_W;
      assign wb_row[r][c*DATA_W +: DATA_W] = sat_data(c_ext - p_ext);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (issue) acc_q <= sum;
  end

  always_ff @(posedge clk_i) begin
    for (int g = 0; g < 3; g++) begin
      if (ld_we[g]) mem_q[g][ld_addr[g]] <= ld_data[g];
    end
    if (issue && k_last) begin
      for (int r = 0; r < S; r++) mem_q[2][c_row_addr[r]] <= wb_row[r];
    end
  end

  assign st_data_o = mem_q[2][st_addr];

  p_ready_load_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rdy_o || b_rdy_o || c_rdy_o) |-> (phase == PH_LOAD));

  p_no_store_calc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> !st_vld_o);

  p_store_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_vld_o && !st_rdy_i) |=> (st_vld_o && $stable(st_data_o)));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

// File: tb/sim_blk_mm_update.sv
module sim_lane #(
  parameter int unsigned BL = 4,
  parameter int unsigned SL = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   n_chk,
  output int   n_bad
);

  localparam int unsigned B  = 1 << BL;
  localparam int unsigned S  = 1 << SL;
  localparam int unsigned N  = B / S;
  localparam int unsigned W  = B * N;
  localparam int unsigned WW = 16 * S;

  logic          start, busy, done;
  logic          a_vld, b_vld, c_vld, a_rdy, b_rdy, c_rdy;
  logic [WW-1:0] a_data, b_data, c_data, st_data;
  logic          st_vld, st_rdy;

  blk_mm_update #(.BLK_LOG(BL), .SUB_LOG(SL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .a_vld_i(a_vld), .a_data_i(a_data), .a_rdy_o(a_rdy),
    .b_vld_i(b_vld), .b_data_i(b_data), .b_rdy_o(b_rdy),
    .c_vld_i(c_vld), .c_data_i(c_data), .c_rdy_o(c_rdy),
    .st_vld_o(st_vld), .st_data_o(st_data), .st_rdy_i(st_rdy)
  );

  int ma [B][B];
  int mb [B][B];
  int mc [B][B];
  int me [B][B];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (B=%0d S=%0d) actual=%0d expected=%0d", req, B, S, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pack(input int sel, input int w);
    logic [WW-1:0] v;
    int row, col;
    row = w / N;
    col = (w % N) * S;
    for (int e = 0; e < S; e++) begin
      if (sel == 0)      v[e*16 +: 16] = 16'(ma[row][col+e]);
      else if (sel == 1) v[e*16 +: 16] = 16'(mb[row][col+e]);
      else               v[e*16 +: 16] = 16'(mc[row][col+e]);
    end
    return v;
  endfunction

  task automatic model();
    for (int r = 0; r < B; r++) begin
      for (int c = 0; c < B; c++) begin
        longint s, d;
        s = 0;
        for (int k = 0; k < B; k++) s += longint'(ma[r][k]) * longint'(mb[k][c]);
        d = longint'(mc[r][c]) - (s >>> 8);
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        me[r][c] = int'(d);
      end
    end
  endtask

  task automatic fill_rand();
    for (int r = 0; r < B; r++) begin
      for (int c = 0; c < B; c++) begin
        ma[r][c] = int'($urandom_range(0, 1023)) - 512;
        mb[r][c] = int'($urandom_range(0, 1023)) - 512;
        mc[r][c] = int'($urandom_range(0, 65535)) - 32768;
      end
    end
  endtask

  task automatic fill_const(input int av, input int bv, input int cv);
    for (int r = 0; r < B; r++) begin
      for (int c = 0; c < B; c++) begin
        ma[r][c] = av;
        mb[r][c] = bv;
        mc[r][c] = cv;
      end
    end
  endtask

  // gap: percent of idle beats per port; ordered: C, then B, then A
  task automatic run_block(input string req, input int gap, input int stall,
                           input bit ordered, input bit poke);
    int ia, ib, ic, it, n, cnt;
    bit pa, pb, pc, prev_stall;
    logic [WW-1:0] prev_data;
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ia = 0; ib = 0; ic = 0; it = 0;
    while (ia < W || ib < W || ic < W) begin
      if (it > 0) @(negedge clk);
      it++;
      start = poke && (it == 3);
      c_vld = (ic < W) && ($urandom_range(0, 99) >= gap);
      b_vld = (ib < W) && (!ordered || ic == W) && ($urandom_range(0, 99) >= gap);
      a_vld = (ia < W) && (!ordered || ib == W) && ($urandom_range(0, 99) >= gap);
      a_data = pack(0, ia);
      b_data = pack(1, ib);
      c_data = pack(2, ic);
      pa = a_vld && a_rdy;
      pb = b_vld && b_rdy;
      pc = c_vld && c_rdy;
      @(posedge clk);
      if (pa) ia++;
      if (pb) ib++;
      if (pc) ic++;
    end
    @(negedge clk);
    a_vld = 1'b0; b_vld = 1'b0; c_vld = 1'b0; start = 1'b0;
    chk(!a_rdy && !b_rdy && !c_rdy, "R1 ready low after full load", {a_rdy, b_rdy, c_rdy}, 0);
    // R2: count low samples of st_vld until it rises
    n = 0;
    while (!st_vld && n < 100000) begin
      n++;
      start = poke && (n == 2);
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == int'(N * N * N + 1), "R2 compute length", n, N * N * N + 1);
    cnt = 0;
    prev_stall = 1'b0;
    prev_data = '0;
    while (cnt < int'(W)) begin
      st_rdy = ($urandom_range(0, 99) >= stall);
      if (prev_stall) begin
        chk(st_vld, "R5 valid held", st_vld, 1);
        chk(st_data == prev_data, "R5 data held", longint'(st_data[15:0]), longint'(prev_data[15:0]));
      end
      if (st_vld && st_rdy) begin
        for (int e = 0; e < int'(S); e++) begin
          int row, col, got;
          row = cnt / N;
          col = (cnt % N) * S + e;
          got = int'($signed(st_data[e*16 +: 16]));
          chk(got == me[row][col], req, got, me[row][col]);
        end
        cnt++;
      end
      prev_stall = st_vld && !st_rdy;
      prev_data = st_data;
      @(negedge clk);
    end
    st_rdy = 1'b0;
    chk(done == 1'b1, "R6 done after last store", done, 1);
    chk(busy == 1'b0, "R6 idle with done", busy, 0);
    chk(st_vld == 1'b0, "R5 no extra store word", st_vld, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    if (poke) chk(busy == 1'b0, "R7 start during job ignored", busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy, "R8 busy after reset", busy, 0);
    chk(!done, "R8 done after reset", done, 0);
    chk(!st_vld, "R8 store valid after reset", st_vld, 0);
    chk(!a_rdy && !b_rdy && !c_rdy, "R8 R1 ready low when idle", {a_rdy, b_rdy, c_rdy}, 0);
  endtask

  task automatic t_plain();
    fill_rand();
    run_block("R3 R1 result, no gaps", 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_gaps();
    fill_rand();
    run_block("R3 R9 result, gaps and stalls", 40, 50, 1'b0, 1'b0);
  endtask

  task automatic t_ordered();
    fill_rand();
    run_block("R3 R9 result, ports in turn", 20, 30, 1'b1, 1'b0);
  endtask

  task automatic t_sat_hi();
    fill_const(32512, -32512, 32000);
    run_block("R4 saturate high", 0, 25, 1'b0, 1'b0);
  endtask

  task automatic t_sat_lo();
    fill_const(32512, 32512, -32000);
    run_block("R4 saturate low", 10, 0, 1'b0, 1'b0);
  endtask

  task automatic t_poke();
    fill_rand();
    run_block("R7 result with start while busy", 30, 30, 1'b0, 1'b1);
  endtask

  initial begin
    fin = 1'b0; n_chk = 0; n_bad = 0;
    start = 1'b0; st_rdy = 1'b0;
    a_vld = 1'b0; b_vld = 1'b0; c_vld = 1'b0;
    a_data = '0; b_data = '0; c_data = '0;
    @(posedge rst_n);
    t_reset();
    t_plain();
    t_gaps();
    t_ordered();
    t_sat_hi();
    t_sat_lo();
    t_poke();
    fin = 1'b1;
  end

endmodule

module sim_blk_mm_update;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic fin0, fin1, fin2;
  int   c0, c1, c2, f0, f1, f2;

  sim_lane #(.BL(4), .SL(2)) u_lane_big   (.clk(clk), .rst_n(rst_n), .fin(fin0), .n_chk(c0), .n_bad(f0));
  sim_lane #(.BL(3), .SL(1)) u_lane_thin  (.clk(clk), .rst_n(rst_n), .fin(fin1), .n_chk(c1), .n_bad(f1));
  sim_lane #(.BL(2), .SL(2)) u_lane_small (.clk(clk), .rst_n(rst_n), .fin(fin2), .n_chk(c2), .n_bad(f2));

  initial begin
    int cyc, extra_chk, extra_bad;
    extra_chk = 0;
    extra_bad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(fin0 && fin1 && fin2) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    extra_chk = 1;
    if (!(fin0 && fin1 && fin2)) begin
      extra_bad = 1;
      $display("FAIL watchdog: run hung, actual=%0d expected=%0d", cyc, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             c0 + c1 + c2 + extra_chk, f0 + f1 + f2 + extra_bad);
    $finish;
  end

endmodule